// File: doc/BRIEF.md
# Audio Serial Clock and Frame Generator

This block is the master-side timing source for a two-channel I2S audio port. It chooses one of two audio master clocks, divides it down to a bit clock, and produces the left/right frame clock. It also gives per-bit strobes, a slot position and a data-window indication, which a serializer and a deserializer use to move 16-bit samples through 32-bit slots. The whole design runs on one system clock. Each master clock arrives as an edge strobe: a one-cycle pulse that marks each edge of that master clock, rising or falling. Because the bit-clock ratio counts master periods, the bit clock toggles once every N selected edges.

Software provides the configuration as static inputs: source select, a 4-bit divider code, bit- and frame-clock polarity, word-length codes, transmit/receive enables and a continuous-frame option. The generator copies the configuration into its own registers only while it is stopped. It starts when either direction is enabled, or when continuous frames are requested, and only if the configuration is valid. When both directions are disabled it finishes the current frame, then either stops or keeps running. The idle flag reports that the frame has ended.

Top module: `i2s_clkgen`

## Requirements
- R1: Divider codes 0 to 7 select ratios 1, 2, 4, 8, 16, 32, 64, 128. Codes 8 to 12 select 6, 12, 24, 48, 96. The bit-clock period equals 2·ratio selected master edges.
- R2: Divider codes 13, 14 and 15 are invalid. With an invalid code the generator never starts: bclk stays low and no strobe is issued.
- R3: When use_clk1 is 1 the edges on mck1_edge drive the divider. When it is 0 the edges on mck2_edge drive it.
- R4: A frame has 64 bit positions, counted by {slot_right, bit_pos}, which advance by one on every launch strobe. Positions 0 to 31 are the left slot (slot_right=0) and positions 32 to 63 are the right slot. With default polarity, fclk equals slot_right, so the left slot begins at a falling fclk edge.
- R5: Within a slot, bit_pos 1 to 16 carry data, with data_act=1 and data_idx = 16 − bit_pos (MSB first, index 15 down to 0). bit_pos 0 and 17 to 31 have data_act=0.
- R6: bclk_inv=1 inverts bclk and fclk_inv=1 inverts fclk. With default polarity, launch_stb coincides with a falling bclk and capture_stb with a rising bclk.
- R7: Only system word code 3 (32-bit slot) together with data word code 1 (16-bit data) is valid. Any other pair keeps the generator stopped, with bclk low.
- R8: With frame_keep=1 and both directions disabled, bclk and fclk keep running and idle stays 1.
- R9: idle is 1 after reset. It reads 0 from the cycle after tx_en or rx_en is seen high. After both go low, the generator finishes the current frame without a launch for the wrap position, then stops with bclk low and idle=1.
- R10: The divider code, source select and polarities are sampled only while the generator is stopped. A change while it runs leaves the bit-clock period unchanged.
- R11: Each strobe is a one-cycle pulse in the cycle where bclk has just changed level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mck1_edge | input | 1 | Edge strobe of the first master clock |
| mck2_edge | input | 1 | Edge strobe of the second master clock |
| use_clk1 | input | 1 | 1 selects the first master clock |
| div_code | input | 4 | Bit-clock divider code |
| bclk_inv | input | 1 | Invert bit clock |
| fclk_inv | input | 1 | Invert frame clock |
| swl_code | input | 3 | System word length code |
| dwl_code | input | 3 | Data word length code |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| frame_keep | input | 1 | Keep clocks running while both directions are off |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame (left/right) clock |
| launch_stb | output | 1 | Drive the next data bit |
| capture_stb | output | 1 | Sample the current data bit |
| slot_right | output | 1 | Current slot is the right channel |
| bit_pos | output | 5 | Bit position within the slot |
| data_act | output | 1 | Current position carries a data bit |
| data_idx | output | 4 | Index of the data bit at this position |
| idle | output | 1 | Both directions off and the frame has ended |

## Verification
Several properties are checked on every cycle. A stopped generator is quiet: no bit clock and no strobes. Each strobe falls on a bit-clock transition. Each launch advances the slot position by exactly one. An enable always clears idle. The latched configuration cannot change while the generator runs. Only the bench scenarios can show the exact ratio for each divider code, the choice of master clock, the layout of the data window, the effect of the polarity inversions, the continuous-frame behaviour, and the count of bits finished after a disable before the clocks stop.

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
  parameter int SLOT_BITS = 32,
  parameter int DATA_BITS = 16,
  parameter int SWL_OK    = 3,
  parameter int DWL_OK    = 1,
  parameter int CNT_W     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mck1_edge,
  input  logic       mck2_edge,
  input  logic       use_clk1,
  input  logic [3:0] div_code,
  input  logic       bclk_inv,
  input  logic       fclk_inv,
  input  logic [2:0] swl_code,
  input  logic [2:0] dwl_code,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       frame_keep,
  output logic       bclk,
  output logic       fclk,
  output logic       launch_stb,
  output logic       capture_stb,
  output logic       slot_right,
  output logic [4:0] bit_pos,
  output logic       data_act,
  output logic [3:0] data_idx,
  output logic       idle
);
  localparam int POS_W = $clog2(SLOT_BITS);
  localparam int FRM_W = POS_W + 1;
  localparam int IDX_W = $clog2(DATA_BITS);

  function automatic logic [CNT_W:0] ratio_of(input logic [3:0] c);
    logic [CNT_W:0] r;
    if (!c[3])
      r = {{CNT_W{1'b0}}, 1'b1} << c[2:0];
    else if (c <= 4'd12)
      r = {{(CNT_W-2){1'b0}}, 3'd6} << c[2:0];
    else
      r = '0;
    return r;
  endfunction

  logic [3:0]       div_q;
  logic             src_q, binv_q, finv_q;
  logic             run, braw, idle_q, lst, cst;
  logic [CNT_W-1:0] hcnt;
  logic [FRM_W-1:0] bitc;

  wire active = tx_en | rx_en;
  wire [CNT_W:0] n_in = ratio_of(div_code);
  wire [CNT_W:0] n_q  = ratio_of(div_q);
  wire cfg_ok = (n_in != '0) && (swl_code == 3'(SWL_OK)) && (dwl_code == 3'(DWL_OK));
  wire tick = src_q ? mck1_edge : mck2_edge;
  wire half = run && tick && ({1'b0, hcnt} == n_q - 1'b1);
  wire rise = half && !braw;
  wire fall = half && braw;
  wire wrap = fall && (bitc == '1);
  wire stop = wrap && !active && !frame_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; braw <= 1'b0; hcnt <= '0; bitc <= '0;
      lst <= 1'b0; cst <= 1'b0; idle_q <= 1'b1;
      div_q <= '0; src_q <= 1'b0; binv_q <= 1'b0; finv_q <= 1'b0;
    end else begin
      lst <= fall && !stop;
      cst <= rise;
      if (!run) begin
        div_q  <= div_code;
        src_q  <= use_clk1;
        binv_q <= bclk_inv;
        finv_q <= fclk_inv;
        hcnt   <= '0;
        braw   <= 1'b0;
        bitc   <= '0;
        run    <= (active || frame_keep) && cfg_ok;
      end else begin
        if (tick) hcnt <= half ? '0 : hcnt + 1'b1;
        if (half) braw <= ~braw;
        if (fall) bitc <= bitc + 1'b1;
        if (stop) run <= 1'b0;
      end
      if (active) idle_q <= 1'b0;
      else if (!run || wrap) idle_q <= 1'b1;
    end
  end

  wire [POS_W-1:0] pos = bitc[POS_W-1:0];

  assign bclk        = run & (braw ^ binv_q);
  assign fclk        = bitc[FRM_W-1] ^ finv_q;
  assign slot_right  = bitc[FRM_W-1];
  assign bit_pos     = 5'(pos);
  assign data_act    = run && (pos != '0) && (pos <= POS_W'(DATA_BITS));
  assign data_idx    = 4'(IDX_W'(DATA_BITS) - IDX_W'(pos));
  assign launch_stb  = lst;
  assign capture_stb = cst;
  assign idle        = idle_q;

  a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!bclk && !launch_stb && !capture_stb));

  a_r11_launch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> (bclk != $past(bclk)));

  a_r11_capture_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |-> (bclk != $past(bclk)));

  a_r4_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> (bit_pos == 5'($past(bit_pos) + 1'b1)));

  a_r9_enable_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || rx_en) |=> !idle);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(div_q) && $stable(src_q) && $stable(binv_q) && $stable(finv_q)));
endmodule

// File: tb/i2s_clkgen_test.sv
module i2s_clkgen_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mck1_edge = 1'b1, mck2_edge = 1'b0, use_clk1 = 1'b1;
  logic [3:0] div_code = '0;
  logic bclk_inv = 1'b0, fclk_inv = 1'b0;
  logic [2:0] swl_code = 3'd3, dwl_code = 3'd1;
  logic tx_en = 1'b0, rx_en = 1'b0, frame_keep = 1'b0;
  logic bclk, fclk, launch_stb, capture_stb, slot_right, data_act, idle;
  logic [4:0] bit_pos;
  logic [3:0] data_idx;

  int checks = 0, errors = 0, cyc = 0, m2 = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    m2 = (m2 == 2) ? 0 : m2 + 1;
    mck2_edge = (m2 == 0);
  end

  i2s_clkgen uut (.*);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start(input logic [3:0] code, input logic src);
    @(negedge clk);
    rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0; frame_keep = 1'b0;
    bclk_inv = 1'b0; fclk_inv = 1'b0; swl_code = 3'd3; dwl_code = 3'd1;
    div_code = code; use_clk1 = src;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rise(output int t);
    logic prev;
    t = -1;
    prev = bclk;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bclk && !prev) begin t = cyc; break; end
      prev = bclk;
    end
  endtask

  task automatic period(output int p);
    int t0, t1;
    wait_rise(t0);
    wait_rise(t1);
    p = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
  endtask

  task automatic wait_launch_at(input int p6);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (launch_stb && ({slot_right, bit_pos} == 6'(p6))) break;
    end
  endtask

  task automatic frame_walk(input logic bi, input logic fi);
    int bad4 = 0, bad5 = 0, bad6 = 0, caps = 0;
    start(4'd0, 1'b1);
    bclk_inv = bi; fclk_inv = fi; tx_en = 1'b1;
    wait_launch_at(0);
    for (int k = 1; k <= 64; k++) begin
      int p;
      p = k % 64;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (capture_stb) begin
          caps++;
          if (bclk !== !bi) bad6++;
        end
        if (launch_stb) break;
      end
      if ({slot_right, bit_pos} != 6'(p)) bad4++;
      if (slot_right !== (p >= 32)) bad4++;
      if (fclk !== ((p >= 32) ^ fi)) bad6++;
      if (bclk !== bi) bad6++;
      if (data_act !== ((p % 32) >= 1 && (p % 32) <= 16)) bad5++;
      if (data_act && (data_idx != 4'(16 - (p % 32)))) bad5++;
    end
    check(bad4 == 0, "R4", "frame position mismatches", bad4, 0);
    check(caps == 64, "R4", "bit clocks per frame", caps, 64);
    check(bad5 == 0, "R5", "data window mismatches", bad5, 0);
    check(bad6 == 0, "R6", "polarity mismatches", bad6, 0);
  endtask

  task automatic quiet(input string req, input string what);
    int r = 0, s = 0;
    logic prev;
    prev = bclk;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bclk && !prev) r++;
      if (bclk) r++;
      if (launch_stb || capture_stb) s++;
      prev = bclk;
    end
    check(r == 0 && s == 0, req, what, r + s, 0);
  endtask

  initial begin
    int p, n, cnt;
    repeat (2) @(negedge clk);
    check(bclk == 0 && launch_stb == 0 && capture_stb == 0, "R2", "reset outputs quiet", int'(bclk), 0);
    check(fclk == 0, "R4", "reset fclk", int'(fclk), 0);
    check(idle == 1, "R9", "reset idle", int'(idle), 1);

    for (int c = 0; c <= 12; c++) begin
      n = (c < 8) ? (1 << c) : (6 << (c - 8));
      start(4'(c), 1'b1);
      tx_en = 1'b1;
      period(p);
      check(p == 2 * n, "R1", $sformatf("bclk period code %0d", c), p, 2 * n);
    end

    for (int c = 13; c <= 15; c++) begin
      start(4'(c), 1'b1);
      tx_en = 1'b1;
      quiet("R2", $sformatf("invalid code %0d activity", c));
    end

    for (int c = 0; c <= 3; c++) begin
      start(4'(c), 1'b0);
      rx_en = 1'b1;
      period(p);
      check(p == 6 * (1 << c), "R3", $sformatf("second clock period code %0d", c), p, 6 * (1 << c));
    end

    frame_walk(1'b0, 1'b0);
    frame_walk(1'b1, 1'b1);
    frame_walk(1'b0, 1'b1);

    start(4'd0, 1'b1);
    swl_code = 3'd2; tx_en = 1'b1;
    quiet("R7", "slot code 2 activity");
    start(4'd0, 1'b1);
    dwl_code = 3'd0; tx_en = 1'b1;
    quiet("R7", "data code 0 activity");

    start(4'd0, 1'b1);
    frame_keep = 1'b1;
    period(p);
    check(p == 2, "R8", "kept-running bclk period", p, 2);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      logic f0;
      f0 = fclk;
      @(negedge clk);
      if (fclk != f0) cnt++;
      if (!idle) cnt = -1000;
    end
    check(cnt >= 4, "R8", "fclk toggles with idle high", cnt, 4);

    start(4'd0, 1'b1);
    tx_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check(idle == 0, "R9", "idle after enable", int'(idle), 0);
    wait_launch_at(40);
    tx_en = 1'b0;
    @(negedge clk);
    check(idle == 0, "R9", "idle right after disable", int'(idle), 0);
    cnt = launch_stb ? 1 : 0;
    for (int i = 0; i < 500 && !idle; i++) begin
      @(negedge clk);
      if (launch_stb) cnt++;
    end
    check(idle == 1, "R9", "idle after frame end", int'(idle), 1);
    check(cnt == 23, "R9", "launches after disable", cnt, 23);
    quiet("R9", "activity after stop");
    rx_en = 1'b1;
    @(negedge clk);
    check(idle == 0, "R9", "rx enable clears idle", int'(idle), 0);

    start(4'd2, 1'b1);
    tx_en = 1'b1;
    period(p);
    check(p == 8, "R10", "period before change", p, 8);
    div_code = 4'd0; bclk_inv = 1'b1;
    period(p);
    check(p == 8, "R10", "period after live change", p, 8);

    start(4'd1, 1'b1);
    tx_en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 400; i++) begin
      logic b0;
      b0 = bclk;
      @(negedge clk);
      if (launch_stb && !(b0 && !bclk)) cnt++;
      if (capture_stb && !(!b0 && bclk)) cnt++;
    end
    check(cnt == 0, "R11", "strobes off bclk edges", cnt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule